// File: doc/BRIEF.md
# Custom Instruction Coprocessor Unit

This block runs beside a 32-bit integer ALU. It executes user-defined instructions that use the four opcode slots set aside for custom extensions. The pipeline gives it the raw instruction word, up to four register operands and a start strobe. The unit returns a result for the destination register, a one-cycle done pulse and an illegal-instruction flag. It also decodes the five register specifiers out of the instruction word, so the register file can drive its read ports from them.

Three layouts are decoded:
- A two-source layout with a ten-bit operation selector.
- A three-source layout with a three-bit selector.
- Two five-register layouts with no immediate bits at all. In these, the fourth source specifier is split across two fields.

The operation that the first five-register opcode performs is set by a small command register. A dedicated two-source encoding writes that register. The second five-register opcode is a multi-cycle multiply-accumulate. Every other operation finishes one clock edge after the start. Legality depends on the opcode alone.

Top module: `cx_unit`

## Requirements
- R1: After reset, done_o is 0, result_o is 0 and the command register is 0, so the first five-register A instruction computes the AND of its four operands.
- R2: Opcode 0001011 is the two-source layout. The selector is {instr[31:25], instr[14:12]}. Selector 0 gives rs1 with its bit order reversed. Selector 1 gives the XNOR of rs1 and rs2. Selector 2 gives the sum of the four bytes of rs1. Selector 3 gives the Gray code of rs1. Any other selector, apart from the one in R3, gives 0. The result and done appear after the start edge.
- R3: The two-source selector 0x3F8 (instr[31:25] = 1111111, instr[14:12] = 000) loads rs1[7:0] into the command register and returns rs1 as the result.
- R4: Opcode 0101011 is the three-source layout, selected by instr[14:12]. Value 0 gives rs1+rs2+rs3. Value 1 gives the bitwise majority of the three operands. Value 2 gives (rs1 & rs3) | (rs2 & ~rs3). Other values give 0. Bits [26:25] have no effect on the result. The result appears after the start edge.
- R5: Opcode 1011011 (five-register A) gives rs1&rs2&rs3&rs4 when the command register is 0, and rs1^rs2^rs3^rs4 when it is 1. Any other command value gives 0.
- R6: Opcode 1111011 (five-register B) gives the low 32 bits of rs1*rs2+rs3+rs4. done_o rises after exactly MUL_LAT clock edges, counting the start edge as the first.
- R7: rd_idx_o = instr[11:7], rs1_idx_o = instr[19:15], rs2_idx_o = instr[24:20] and rs3_idx_o = instr[31:27]. rs4_idx_o = {instr[26:25], instr[14:12]}.
- R8: done_o is high for exactly one cycle for each accepted start. result_o then holds its value until the next completion.
- R9: A start that arrives while a multiply-accumulate is running is ignored. It produces no extra done pulse, no command register change and no change to the pending result.
- R10: With ENABLE=1, illegal_o is always 0, including for custom instructions whose register-field MSBs are set. A start with an opcode outside the four custom slots produces no done pulse.
- R11: With ENABLE=0, illegal_o equals start_i combinationally whenever the opcode is one of the four custom slots, and done_o never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for the instruction on instr_i |
| instr_i | input | 32 | Instruction word |
| rs1_i | input | XLEN | First source operand |
| rs2_i | input | XLEN | Second source operand |
| rs3_i | input | XLEN | Third source operand |
| rs4_i | input | XLEN | Fourth source operand |
| result_o | output | XLEN | Result for the destination register |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Illegal custom instruction flag |
| rd_idx_o | output | 5 | Destination specifier |
| rs1_idx_o | output | 5 | First source specifier |
| rs2_idx_o | output | 5 | Second source specifier |
| rs3_idx_o | output | 5 | Third source specifier |
| rs4_idx_o | output | 5 | Fourth source specifier, split field |

## Verification
Two events can fall on the same clock edge:
- The multiply-accumulate finishing.
- A new start, in particular a command-register write.

The bench launches a five-register B instruction. It then holds a command write on the start line both on the edge right after the launch and on the edge where the multiply completes. The check expects exactly one done pulse, on the completion edge, carrying the multiply result. A following five-register A instruction must still use the command value written before the launch.

// File: rtl/cx_pkg.sv
package cx_pkg;
   localparam logic [6:0] OPC_R3  = 7'b0001011;
   localparam logic [6:0] OPC_R4  = 7'b0101011;
   localparam logic [6:0] OPC_R5A = 7'b1011011;
   localparam logic [6:0] OPC_R5B = 7'b1111011;

   typedef enum logic [2:0] {
      FMT_NONE,
      FMT_R3,
      FMT_R4,
      FMT_R5A,
      FMT_R5B
   } cx_fmt_e;

   localparam logic [9:0] SEL_BITREV = 10'h000;
   localparam logic [9:0] SEL_XNOR   = 10'h001;
   localparam logic [9:0] SEL_BSUM   = 10'h002;
   localparam logic [9:0] SEL_GRAY   = 10'h003;
   localparam logic [9:0] SEL_CMDWR  = 10'h3F8;
endpackage

// File: rtl/cx_decode.sv
module cx_decode
   import cx_pkg::*;
(
   input  logic [31:0] instr_i,
   output cx_fmt_e     fmt_o,
   output logic [9:0]  sel_o,
   output logic [4:0]  rd_idx_o,
   output logic [4:0]  rs1_idx_o,
   output logic [4:0]  rs2_idx_o,
   output logic [4:0]  rs3_idx_o,
   output logic [4:0]  rs4_idx_o
);
   always_comb begin
      case (instr_i[6:0])
         OPC_R3:  fmt_o = FMT_R3;
         OPC_R4:  fmt_o = FMT_R4;
         OPC_R5A: fmt_o = FMT_R5A;
         OPC_R5B: fmt_o = FMT_R5B;
         default: fmt_o = FMT_NONE;
      endcase
   end

   // selector: high seven bits then low three bits
   assign sel_o     = {instr_i[31:25], instr_i[14:12]};
   assign rd_idx_o  = instr_i[11:7];
   assign rs1_idx_o = instr_i[19:15];
   assign rs2_idx_o = instr_i[24:20];
   assign rs3_idx_o = instr_i[31:27];
   // split fourth specifier: upper two bits sit above rs2, lower three in the funct3 slot
   assign rs4_idx_o = {instr_i[26:25], instr_i[14:12]};
endmodule

// File: rtl/cx_ops.sv
module cx_ops
   import cx_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int CMD_W = 8
) (
   input  cx_fmt_e          fmt_i,
   input  logic [9:0]       sel_i,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic [XLEN-1:0]  rs1_i,
   input  logic [XLEN-1:0]  rs2_i,
   input  logic [XLEN-1:0]  rs3_i,
   input  logic [XLEN-1:0]  rs4_i,
   output logic [XLEN-1:0]  res_o,
   output logic             cmd_wr_o
);
   localparam int NBYTES = XLEN / 8;

   assign cmd_wr_o = (fmt_i == FMT_R3) && (sel_i == SEL_CMDWR);

   always_comb begin
      res_o = '0;
      case (fmt_i)
         FMT_R3: begin
            case (sel_i)
               SEL_BITREV: for (int i = 0; i < XLEN; i++) res_o[i] = rs1_i[XLEN-1-i];
               SEL_XNOR:   res_o = ~(rs1_i ^ rs2_i);
               SEL_BSUM:   for (int i = 0; i < NBYTES; i++)
                              res_o = res_o + XLEN'(rs1_i[8*i +: 8]);
               SEL_GRAY:   res_o = rs1_i ^ (rs1_i >> 1);
               SEL_CMDWR:  res_o = rs1_i;
               default:    res_o = '0;
            endcase
         end
         FMT_R4: begin
            case (sel_i[2:0])
               3'd0:    res_o = rs1_i + rs2_i + rs3_i;
               3'd1:    res_o = (rs1_i & rs2_i) | (rs1_i & rs3_i) | (rs2_i & rs3_i);
               3'd2:    res_o = (rs1_i & rs3_i) | (rs2_i & ~rs3_i);
               default: res_o = '0;
            endcase
         end
         FMT_R5A: begin
            if (cmd_i == CMD_W'(0))      res_o = rs1_i & rs2_i & rs3_i & rs4_i;
            else if (cmd_i == CMD_W'(1)) res_o = rs1_i ^ rs2_i ^ rs3_i ^ rs4_i;
            else                         res_o = '0;
         end
         default: res_o = '0;
      endcase
   end
endmodule

// File: rtl/cx_mul.sv
module cx_mul #(
   parameter int XLEN = 32,
   parameter int LAT  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            launch_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic [XLEN-1:0] c_i,
   input  logic [XLEN-1:0] d_i,
   output logic            busy_o,
   output logic            fin_o,
   output logic [XLEN-1:0] res_o
);
   localparam int CW = $clog2(LAT + 1);

   logic [XLEN-1:0] a_q, b_q, c_q, d_q;
   logic [CW-1:0]   cnt_q;
   logic            busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         a_q    <= '0;
         b_q    <= '0;
         c_q    <= '0;
         d_q    <= '0;
      end else if (launch_i) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(LAT - 1);
         a_q    <= a_i;
         b_q    <= b_i;
         c_q    <= c_i;
         d_q    <= d_i;
      end else if (busy_q) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CW'(1)) busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;
   assign fin_o  = busy_q && (cnt_q == CW'(1));
   assign res_o  = a_q * b_q + c_q + d_q;

   p_launch_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i |-> !busy_q);
   p_launch_no_early_fin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i |=> (busy_q && !fin_o));
endmodule

// File: rtl/cx_unit.sv
module cx_unit
   import cx_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int CMD_W   = 8,
   parameter int MUL_LAT = 4,
   parameter bit ENABLE  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [31:0]     instr_i,
   input  logic [XLEN-1:0] rs1_i,
   input  logic [XLEN-1:0] rs2_i,
   input  logic [XLEN-1:0] rs3_i,
   input  logic [XLEN-1:0] rs4_i,
   output logic [XLEN-1:0] result_o,
   output logic            done_o,
   output logic            illegal_o,
   output logic [4:0]      rd_idx_o,
   output logic [4:0]      rs1_idx_o,
   output logic [4:0]      rs2_idx_o,
   output logic [4:0]      rs3_idx_o,
   output logic [4:0]      rs4_idx_o
);
   if (XLEN != 32) begin : g_bad_xlen
      $error("cx_unit: XLEN must be 32");
   end
   if (MUL_LAT < 2) begin : g_bad_lat
      $error("cx_unit: MUL_LAT must be at least 2");
   end
   if (CMD_W < 1 || CMD_W > XLEN) begin : g_bad_cmd
      $error("cx_unit: CMD_W out of range");
   end

   cx_fmt_e    fmt;
   logic [9:0] sel;

   cx_decode u_dec (
      .instr_i   (instr_i),
      .fmt_o     (fmt),
      .sel_o     (sel),
      .rd_idx_o  (rd_idx_o),
      .rs1_idx_o (rs1_idx_o),
      .rs2_idx_o (rs2_idx_o),
      .rs3_idx_o (rs3_idx_o),
      .rs4_idx_o (rs4_idx_o)
   );

   if (ENABLE) begin : g_on
      logic [XLEN-1:0]  op_res, mul_res, result_q;
      logic [CMD_W-1:0] cmd_q;
      logic             cmd_wr, mul_busy, mul_fin, done_q, accept, launch;

      cx_ops #(.XLEN(XLEN), .CMD_W(CMD_W)) u_ops (
         .fmt_i    (fmt),
         .sel_i    (sel),
         .cmd_i    (cmd_q),
         .rs1_i    (rs1_i),
         .rs2_i    (rs2_i),
         .rs3_i    (rs3_i),
         .rs4_i    (rs4_i),
         .res_o    (op_res),
         .cmd_wr_o (cmd_wr)
      );

      assign accept = start_i && (fmt != FMT_NONE) && !mul_busy;
      assign launch = accept && (fmt == FMT_R5B);

      cx_mul #(.XLEN(XLEN), .LAT(MUL_LAT)) u_mul (
         .clk      (clk),
         .rst_n    (rst_n),
         .launch_i (launch),
         .a_i      (rs1_i),
         .b_i      (rs2_i),
         .c_i      (rs3_i),
         .d_i      (rs4_i),
         .busy_o   (mul_busy),
         .fin_o    (mul_fin),
         .res_o    (mul_res)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
            cmd_q    <= '0;
         end else begin
            done_q <= 1'b0;
            if (mul_fin) begin
               result_q <= mul_res;
               done_q   <= 1'b1;
            end else if (accept && !launch) begin
               result_q <= op_res;
               done_q   <= 1'b1;
               if (cmd_wr) cmd_q <= rs1_i[CMD_W-1:0];
            end
         end
      end

      assign result_o  = result_q;
      assign done_o    = done_q;
      assign illegal_o = 1'b0;

      p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
         done_o |=> !done_o);
      p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(done_o) |-> $stable(result_o));
      p_busy_keeps_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (mul_busy && start_i) |=> $stable(cmd_q));
   end else begin : g_off
      logic unused_ok;
      assign unused_ok = ^{clk, rst_n, sel, rs1_i, rs2_i, rs3_i, rs4_i};
      assign result_o  = '0;
      assign done_o    = 1'b0;
      assign illegal_o = start_i && (fmt != FMT_NONE);
   end
endmodule

// File: tb/cx_unit_tb.sv
`timescale 1ns/1ps
module cx_unit_tb;
   localparam int LAT = 4;
   localparam logic [6:0] O3 = 7'b0001011, O4 = 7'b0101011, O5A = 7'b1011011, O5B = 7'b1111011;

   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [31:0] instr = '0, a = '0, b = '0, c = '0, d = '0;
   logic [31:0] res, res_off;
   logic        done, ill, done_off, ill_off;
   logic [4:0]  rd_i, r1_i, r2_i, r3_i, r4_i;
   logic [4:0]  o_rd, o_r1, o_r2, o_r3, o_r4;
   int          n_chk = 0, n_fail = 0;
   logic [7:0]  cmd_model = 8'h00;

   always #2.5 clk = ~clk;

   cx_unit #(.MUL_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .instr_i(instr),
      .rs1_i(a), .rs2_i(b), .rs3_i(c), .rs4_i(d),
      .result_o(res), .done_o(done), .illegal_o(ill),
      .rd_idx_o(rd_i), .rs1_idx_o(r1_i), .rs2_idx_o(r2_i), .rs3_idx_o(r3_i), .rs4_idx_o(r4_i));

   cx_unit #(.MUL_LAT(LAT), .ENABLE(1'b0)) u_off (
      .clk(clk), .rst_n(rst_n), .start_i(start), .instr_i(instr),
      .rs1_i(a), .rs2_i(b), .rs3_i(c), .rs4_i(d),
      .result_o(res_off), .done_o(done_off), .illegal_o(ill_off),
      .rd_idx_o(o_rd), .rs1_idx_o(o_r1), .rs2_idx_o(o_r2), .rs3_idx_o(o_r3), .rs4_idx_o(o_r4));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] f_rev(input logic [31:0] x);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[31-i] = x[i];
      return r;
   endfunction
   function automatic logic [31:0] f_bsum(input logic [31:0] x);
      return 32'(x[7:0]) + 32'(x[15:8]) + 32'(x[23:16]) + 32'(x[31:24]);
   endfunction
   function automatic logic [31:0] f_gray(input logic [31:0] x);
      return x ^ {1'b0, x[31:1]};
   endfunction
   function automatic logic [31:0] f_maj(input logic [31:0] x, y, z);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = (32'(x[i]) + 32'(y[i]) + 32'(z[i])) >= 2;
      return r;
   endfunction
   function automatic logic [31:0] r3(input logic [6:0] f7, input logic [2:0] f3);
      return {f7, 5'($urandom), 5'($urandom), f3, 5'($urandom), O3};
   endfunction
   function automatic logic [31:0] r4(input logic [2:0] f3, input logic [1:0] hi);
      return {5'($urandom), hi, 5'($urandom), 5'($urandom), f3, 5'($urandom), O4};
   endfunction
   function automatic logic [31:0] r5(input logic [6:0] opc, input logic [4:0] s4, s3, s2, s1, dd);
      return {s3, s4[4:3], s2, s1, s4[2:0], dd, opc};
   endfunction

   task automatic do_op(input logic [31:0] ins, input logic [31:0] va, vb, vc, vd,
                        input logic [31:0] exp, input int exp_lat, input string tag);
      int lat;
      logic [31:0] got;
      @(negedge clk);
      instr = ins; a = va; b = vb; c = vc; d = vd; start = 1'b1;
      #1;
      chk(ill == 1'b0, "R10 enabled unit flags no custom op", 32'(ill), 32'd0);
      chk(ill_off == 1'b1, "R11 disabled unit flags custom op", 32'(ill_off), 32'd1);
      @(posedge clk); #1;
      start = 1'b0;
      lat = 1;
      while (!done && lat < 30) begin
         @(posedge clk); #1;
         lat++;
      end
      got = res;
      chk(done === 1'b1 && got === exp, tag, got, exp);
      chk(lat == exp_lat, {tag, " latency"}, 32'(lat), 32'(exp_lat));
      chk(done_off == 1'b0, "R11 disabled unit never done", 32'(done_off), 32'd0);
      @(posedge clk); #1;
      chk(done === 1'b0 && res === got, "R8 single pulse and held result", res, got);
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] x, y, z, w, ins;
      void'($urandom(32'd7331));
      repeat (3) @(posedge clk);
      #1;
      chk(done == 1'b0, "R1 done low after reset", 32'(done), 32'd0);
      chk(res == 32'd0, "R1 result zero after reset", res, 32'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(done == 1'b0 && res == 32'd0, "R1 idle after reset release", res, 32'd0);

      // R1: command register resets to 0 -> AND
      do_op(r5(O5A, 5'd9, 5'd3, 5'd2, 5'd1, 5'd4), 32'hF0F0_FFFF, 32'hFF00_F0FF, 32'hFFFF_00FF, 32'hFFF0_FFF0,
            32'hF000_00F0, 1, "R1 reset command selects AND");

      // R7: field extraction
      @(negedge clk);
      instr = r5(O5B, 5'b10110, 5'b01101, 5'b11100, 5'b00011, 5'b10001);
      #1;
      chk(r4_i == 5'b10110, "R7 split fourth specifier", 32'(r4_i), 32'b10110);
      chk(r3_i == 5'b01101, "R7 third specifier", 32'(r3_i), 32'b01101);
      chk(r2_i == 5'b11100 && r1_i == 5'b00011 && rd_i == 5'b10001, "R7 rs2 rs1 rd specifiers",
          {17'd0, r2_i, r1_i, rd_i}, {17'd0, 15'b11100_00011_10001});

      // R2 directed
      x = 32'h8000_0001; do_op(r3(7'd0, 3'd0), x, 0, 0, 0, f_rev(x), 1, "R2 bit reverse corner");
      x = 32'h1234_5678; do_op(r3(7'd0, 3'd0), x, 0, 0, 0, f_rev(x), 1, "R2 bit reverse");
      do_op(r3(7'd0, 3'd1), 32'hAAAA_0000, 32'h5555_0000, 0, 0, 32'h0000_FFFF, 1, "R2 xnor");
      do_op(r3(7'd0, 3'd2), 32'hFFFF_FFFF, 0, 0, 0, 32'd1020, 1, "R2 byte sum max");
      do_op(r3(7'd0, 3'd3), 32'hFFFF_FFFF, 0, 0, 0, 32'h8000_0000, 1, "R2 gray code");
      do_op(r3(7'h01, 3'd0), 32'h1234_5678, 32'h1, 0, 0, 32'd0, 1, "R2 undefined selector gives zero");

      // R4 directed, with bits [26:25] set
      do_op(r4(3'd0, 2'b11), 32'd10, 32'd20, 32'hFFFF_FFFF, 0, 32'd29, 1, "R4 three-way add with wrap");
      do_op(r4(3'd1, 2'b10), 32'hFF00_FF00, 32'hF0F0_F0F0, 32'h0F0F_FFFF, 0,
            f_maj(32'hFF00_FF00, 32'hF0F0_F0F0, 32'h0F0F_FFFF), 1, "R4 majority ignores bits 26:25");
      do_op(r4(3'd2, 2'b01), 32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_0000, 0, 32'hAAAA_5555, 1, "R4 select");
      do_op(r4(3'd5, 2'b00), 32'h1, 32'h2, 32'h3, 0, 32'd0, 1, "R4 undefined selector gives zero");

      // R3 command write, then R5
      do_op(r3(7'h7F, 3'd0), 32'hDEAD_BE01, 0, 0, 0, 32'hDEAD_BE01, 1, "R3 command write returns rs1");
      cmd_model = 8'h01;
      do_op(r5(O5A, 5'd31, 5'd30, 5'd29, 5'd28, 5'd1), 32'h1111_1111, 32'h2222_2222, 32'h4444_4444, 32'h8888_8888,
            32'hFFFF_FFFF, 1, "R5 command 1 selects XOR");
      do_op(r3(7'h7F, 3'd0), 32'h0000_0007, 0, 0, 0, 32'h7, 1, "R3 command write value 7");
      do_op(r5(O5A, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
            32'd0, 1, "R5 other command value gives zero");
      do_op(r3(7'h7F, 3'd0), 32'h0000_0100, 0, 0, 0, 32'h100, 1, "R3 command write uses low byte only");
      cmd_model = 8'h00;
      do_op(r5(O5A, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5), 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
            32'h0F0F_0F0F, 1, "R5 command 0 selects AND");

      // R6 multiply-accumulate
      do_op(r5(O5B, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5), 32'd1000, 32'd3000, 32'd7, 32'd11, 32'd3000018, LAT, "R6 multiply-add");
      do_op(r5(O5B, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd2,
            32'h0000_0002, LAT, "R6 multiply-add wraps to 32 bits");

      // R9: starts during busy, including the completion edge
      @(negedge clk);
      instr = r5(O5B, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5); a = 32'd6; b = 32'd7; c = 32'd8; d = 32'd9; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      for (int k = 1; k < LAT; k++) begin
         @(negedge clk);
         if (k == 1 || k == LAT - 1) begin
            instr = r3(7'h7F, 3'd0); a = 32'h0000_0001; start = 1'b1;
         end
         @(posedge clk); #1;
         start = 1'b0;
         if (k == LAT - 1)
            chk(done == 1'b1 && res == 32'd59, "R9 completion wins over colliding start", res, 32'd59);
         else
            chk(done == 1'b0, "R9 no done while busy", 32'(done), 32'd0);
      end
      @(posedge clk); #1;
      chk(done == 1'b0, "R9 ignored start yields no extra done", 32'(done), 32'd0);
      do_op(r5(O5A, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5), 32'hFF, 32'h0F, 32'hFF, 32'hFF, 32'h0F, 1,
            "R9 command unchanged by ignored write");

      // R10: non-custom opcode, no done, no illegal
      @(negedge clk);
      instr = {25'h1FF_FFFF, 7'b0110011}; start = 1'b1;
      #1;
      chk(ill == 1'b0 && ill_off == 1'b0, "R10 R11 non-custom opcode not flagged", {30'd0, ill, ill_off}, 32'd0);
      @(posedge clk); #1;
      start = 1'b0;
      repeat (LAT + 1) begin
         chk(done == 1'b0, "R10 non-custom opcode gives no done", 32'(done), 32'd0);
         @(posedge clk); #1;
      end
      // R11: disabled unit idle strobe
      @(negedge clk);
      instr = {25'd0, O4}; start = 1'b0;
      #1;
      chk(ill_off == 1'b0, "R11 no flag without start", 32'(ill_off), 32'd0);

      // R10: register MSBs all set on custom opcodes
      do_op({7'd0, 5'h1F, 5'h1F, 3'd1, 5'h1F, O3}, 32'h0, 32'h0, 0, 0, 32'hFFFF_FFFF, 1, "R10 register MSBs unchecked");

      // random mix, R2 R4 R5
      for (int n = 0; n < 40; n++) begin
         int kind;
         x = $urandom; y = $urandom; z = $urandom; w = $urandom;
         kind = int'($urandom % 7);
         case (kind)
            0: do_op(r3(7'd0, 3'd0), x, y, z, w, f_rev(x), 1, "R2 random bit reverse");
            1: do_op(r3(7'd0, 3'd1), x, y, z, w, ~(x ^ y), 1, "R2 random xnor");
            2: do_op(r3(7'd0, 3'd2), x, y, z, w, f_bsum(x), 1, "R2 random byte sum");
            3: do_op(r3(7'd0, 3'd3), x, y, z, w, f_gray(x), 1, "R2 random gray");
            4: do_op(r4(3'd0, 2'($urandom)), x, y, z, w, x + y + z, 1, "R4 random add");
            5: do_op(r4(3'd1, 2'($urandom)), x, y, z, w, f_maj(x, y, z), 1, "R4 random majority");
            default: begin
               ins = r5(O5A, 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
               do_op(ins, x, y, z, w, (cmd_model == 8'h00) ? (x & y & z & w) : (x ^ y ^ z ^ w), 1,
                     "R5 random five-register A");
            end
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule